// File: doc/BRIEF.md
# Serial Frame Alignment Synchronizer

This block takes a serial bit stream, one bit per clock, and recovers the frame boundaries in it. Every field in the stream is sent least significant bit first. Each frame begins with a short alignment pattern whose value is 13 (001101 as a six-bit word, sent as 1,0,1,1,0,0). The block keeps the most recent frame's worth of bits in a shift buffer and compares the oldest bits of that window against the pattern. A frame is 32 or 16 bits long, selected by `shortFrame`. The pattern length is 4, 5 or 6 bits, selected by `fawSel`. With a shorter pattern, the unused upper pattern bits count as the first data bits.

While hunting, the block tests every bit position. A hit starts a confirmation phase in which only the frame-periodic position is tested. Three consecutive periodic hits declare lock. Once locked, the block tests once per frame. It fires a one-cycle strobe and presents the frame's contents after the pattern as a parallel word. Two consecutive periodic misses drop lock.

Top module: `frame_sync`

## Requirements
- R1: A low `rstN` at a clock edge clears the shift buffer, the phase counter and the lock state. From the next cycle on, `locked`, `strobe` and `payload` read 0.
- R2: One bit enters per clock. The window is the last N bits received (N=32 when `shortFrame`=0, N=16 when `shortFrame`=1). Window bit 0 is the oldest bit.
- R3: The pattern length L is 4 for `fawSel`=0, 5 for `fawSel`=1, and 6 for `fawSel`=2 or 3. A hit means window bits 0..L-1 equal the low L bits of 13 (bit 0 = 1, bit 1 = 0, bit 2 = 1, bit 3 = 1, bits 4 and 5 = 0).
- R4: Starting from a hunt, a hit at any bit position followed by hits exactly N and 2N cycles later raises `locked` in the cycle after the third hit.
- R5: Before lock, a miss at the expected frame-periodic position abandons confirmation. Hunting at every bit position resumes in the following cycle.
- R6: While locked, a single periodic miss keeps lock, and a periodic hit clears the miss tally. A second consecutive periodic miss drops `locked` in the following cycle.
- R7: `strobe` is high for exactly one cycle in a cycle where the block is locked, sits at the frame-periodic position and sees a hit. It never fires while unlocked, so the first strobe comes one frame after lock.
- R8: In a strobe cycle, `payload` holds window bits L..N-1 at bit positions 0..N-1-L, with the upper bits zero. Outside strobe cycles `payload` is zero.
- R9: While locked, pattern hits at positions other than the frame-periodic one are ignored. They neither move the strobe nor affect lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| serialIn | input | 1 | Serial data, least significant bit first |
| shortFrame | input | 1 | 0 selects 32-bit frames, 1 selects 16-bit frames |
| fawSel | input | 2 | Pattern length: 0 gives 4 bits, 1 gives 5 bits, 2 or 3 give 6 bits |
| strobe | output | 1 | One-cycle frame-found pulse while locked |
| locked | output | 1 | Frame lock status |
| payload | output | 32 | Frame contents after the pattern, valid in the strobe cycle |

## Verification
Each frame-length and pattern-length combination gets the same sequence of streams. Clean frames show lock acquisition and strobe spacing. Two good frames followed by a corrupted one separate a proper confirmation restart from a premature lock. Single and double corrupted frames while locked separate the miss tolerance from the drop rule. A frame whose data carries the pattern at a non-periodic offset shows that off-phase hits are ignored once locked. Data is otherwise random but constrained, so the pattern cannot appear by accident and phase lock at a false offset is ruled out. A behavioural reference that keeps the received bits in a queue predicts `strobe`, `locked` and `payload` on every cycle.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  // Hunting / confirming / locked
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } sync_state_e;

  // Control-to-datapath command strobes
  typedef struct packed {
    logic emit;   // publish the current window this cycle
  } sync_cmd_t;

endpackage

// File: rtl/fsync_datapath.sv
module fsync_datapath
  import fsync_pkg::*;
#(
  parameter int unsigned FRAME_LONG  = 32,
  parameter int unsigned FRAME_SHORT = 16,
  parameter int unsigned FAW_MAX     = 6,
  parameter logic [FAW_MAX-1:0] FAW_WORD = 6'd13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serialIn,
  input  logic                  shortFrame,
  input  logic [1:0]            fawSel,
  input  sync_cmd_t             cmd,
  output logic                  fawHit,
  output logic                  strobe,
  output logic [FRAME_LONG-1:0] payload
);

  localparam int unsigned FL_W    = $clog2(FAW_MAX + 1);
  localparam int unsigned PAD_W   = FRAME_LONG - FRAME_SHORT;

  logic [FRAME_LONG-1:0] shiftBuf;
  logic [FRAME_LONG-1:0] window;
  logic [FL_W-1:0]       fawLen;
  logic [FAW_MAX-1:0]    bitOk;

  // Newest bit enters at the top; oldest sits at bit 0 (LSB-first stream)
  always_ff @(posedge clk) begin
    if (!rstN) shiftBuf <= '0;
    else       shiftBuf <= {serialIn, shiftBuf[FRAME_LONG-1:1]};
  end

  // The window is the last N received bits, oldest at bit 0
  always_comb begin
    if (shortFrame) window = {{PAD_W{1'b0}}, shiftBuf[FRAME_LONG-1 -: FRAME_SHORT]};
    else            window = shiftBuf;
  end

  always_comb begin
    unique case (fawSel)
      2'd0:    fawLen = FL_W'(FAW_MAX - 2);
      2'd1:    fawLen = FL_W'(FAW_MAX - 1);
      default: fawLen = FL_W'(FAW_MAX);
    endcase
  end

  // Per-bit pattern compare; bits beyond the chosen length are don't-care
  for (genvar g = 0; g < FAW_MAX; g++) begin : g_fawbit
    assign bitOk[g] = (FL_W'(g) >= fawLen) || (window[g] == FAW_WORD[g]);
  end

  assign fawHit  = &bitOk;
  assign strobe  = cmd.emit;
  assign payload = cmd.emit ? (window >> fawLen) : '0;

  // R7: strobes are a frame apart, never back to back
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

endmodule

// File: rtl/fsync_control.sv
module fsync_control
  import fsync_pkg::*;
#(
  parameter int unsigned FRAME_LONG     = 32,
  parameter int unsigned FRAME_SHORT    = 16,
  parameter int unsigned HITS_TO_LOCK   = 3,
  parameter int unsigned MISSES_TO_DROP = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      shortFrame,
  input  logic      fawHit,
  output sync_cmd_t cmd,
  output logic      locked
);

  localparam int unsigned PH_W   = $clog2(FRAME_LONG);
  localparam int unsigned HIT_W  = $clog2(HITS_TO_LOCK + 1);
  localparam int unsigned MISS_W = $clog2(MISSES_TO_DROP + 1);

  sync_state_e       state, stateNext;
  logic [PH_W-1:0]   phase, phaseNext, phaseStep, frameLast;
  logic [HIT_W-1:0]  hitCnt, hitNext;
  logic [MISS_W-1:0] missCnt, missNext;
  logic              checkSlot;

  assign frameLast = shortFrame ? PH_W'(FRAME_SHORT - 1) : PH_W'(FRAME_LONG - 1);
  assign phaseStep = (phase == frameLast) ? '0 : phase + 1'b1;
  assign checkSlot = (phase == '0);

  always_comb begin
    stateNext = state;
    phaseNext = phaseStep;
    hitNext   = hitCnt;
    missNext  = missCnt;
    unique case (state)
      ST_SEARCH: begin
        if (fawHit) begin
          stateNext = ST_CONFIRM;
          hitNext   = HIT_W'(1);
          phaseNext = PH_W'(1);
        end else begin
          phaseNext = '0;
        end
      end
      ST_CONFIRM: begin
        if (checkSlot) begin
          if (!fawHit) begin
            stateNext = ST_SEARCH;
          end else if (hitCnt == HIT_W'(HITS_TO_LOCK - 1)) begin
            stateNext = ST_LOCKED;
            missNext  = '0;
          end else begin
            hitNext = hitCnt + 1'b1;
          end
        end
      end
      ST_LOCKED: begin
        if (checkSlot) begin
          if (fawHit) begin
            missNext = '0;
          end else if (missCnt == MISS_W'(MISSES_TO_DROP - 1)) begin
            stateNext = ST_SEARCH;
          end else begin
            missNext = missCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      phase   <= '0;
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      state   <= stateNext;
      phase   <= phaseNext;
      hitCnt  <= hitNext;
      missCnt <= missNext;
    end
  end

  assign locked   = (state == ST_LOCKED);
  assign cmd.emit = locked && checkSlot && fawHit;

  // R1: the cycle after reset shows no lock
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !locked);

  // R4: lock only ever follows a pattern hit
  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(fawHit));

  // R6: lock is lost only on a miss
  p_lock_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(locked) && $past(rstN)) |-> !$past(fawHit));

endmodule

// File: rtl/frame_sync.sv
module frame_sync
  import fsync_pkg::*;
#(
  parameter int unsigned FRAME_LONG     = 32,
  parameter int unsigned FRAME_SHORT    = 16,
  parameter int unsigned FAW_MAX        = 6,
  parameter logic [FAW_MAX-1:0] FAW_WORD = 6'd13,
  parameter int unsigned HITS_TO_LOCK   = 3,
  parameter int unsigned MISSES_TO_DROP = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serialIn,
  input  logic                  shortFrame,
  input  logic [1:0]            fawSel,
  output logic                  strobe,
  output logic                  locked,
  output logic [FRAME_LONG-1:0] payload
);

  sync_cmd_t cmd;
  logic      fawHit;

  fsync_datapath #(
    .FRAME_LONG (FRAME_LONG),
    .FRAME_SHORT(FRAME_SHORT),
    .FAW_MAX    (FAW_MAX),
    .FAW_WORD   (FAW_WORD)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .shortFrame(shortFrame),
    .fawSel    (fawSel),
    .cmd       (cmd),
    .fawHit    (fawHit),
    .strobe    (strobe),
    .payload   (payload)
  );

  fsync_control #(
    .FRAME_LONG    (FRAME_LONG),
    .FRAME_SHORT   (FRAME_SHORT),
    .HITS_TO_LOCK  (HITS_TO_LOCK),
    .MISSES_TO_DROP(MISSES_TO_DROP)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .shortFrame(shortFrame),
    .fawHit    (fawHit),
    .cmd       (cmd),
    .locked    (locked)
  );

endmodule

// File: tb/frame_sync_tb.sv
`timescale 1ns/1ps
module frame_sync_tb;

  localparam logic [5:0] FAW6 = 6'd13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialIn = 1'b0;
  logic        shortFrame = 1'b0;
  logic [1:0]  fawSel = 2'd2;
  logic        strobe, locked;
  logic [31:0] payload;

  always #2.5 clk = ~clk;

  frame_sync u_dut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .shortFrame(shortFrame),
    .fawSel(fawSel), .strobe(strobe), .locked(locked), .payload(payload)
  );

  int compared = 0;
  int mismatched = 0;
  int strobeSeen = 0;
  bit finished = 0;

  // Reference model state
  bit q[$];
  int mStatus, mPhase, mHits, mMiss;
  int frameN = 32;
  int fawL = 6;
  bit fb[32];
  int l1, l2, l3;

  function automatic bit winBit(int k);
    return q[q.size() - frameN + k];
  endfunction

  function automatic bit modelHit();
    for (int k = 0; k < fawL; k++)
      if (winBit(k) != FAW6[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelReset();
    q.delete();
    for (int i = 0; i < 32; i++) q.push_back(1'b0);
    mStatus = 0; mPhase = 0; mHits = 0; mMiss = 0;
  endtask

  task automatic modelAdvance(input bit b);
    bit h = modelHit();
    bit atSlot = (mPhase == 0);
    case (mStatus)
      0: begin
        if (h) begin mStatus = 1; mHits = 1; mPhase = 1; end
        else mPhase = 0;
      end
      1: begin
        mPhase = (mPhase + 1) % frameN;
        if (atSlot) begin
          if (!h) mStatus = 0;
          else begin
            mHits++;
            if (mHits == 3) begin mStatus = 2; mMiss = 0; end
          end
        end
      end
      default: begin
        mPhase = (mPhase + 1) % frameN;
        if (atSlot) begin
          if (h) mMiss = 0;
          else begin
            mMiss++;
            if (mMiss == 2) mStatus = 0;
          end
        end
      end
    endcase
    q.push_back(b);
    void'(q.pop_front());
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOutputs();
    bit eStrobe, eLocked;
    logic [31:0] ePay = '0;
    eLocked = (mStatus == 2);
    eStrobe = eLocked && (mPhase == 0) && modelHit();
    if (eStrobe)
      for (int k = fawL; k < frameN; k++) ePay[k - fawL] = winBit(k);
    checkBit("R4 R5 R6 locked", locked, eLocked);
    checkBit("R7 R9 strobe", strobe, eStrobe);
    compared++;
    if (payload !== ePay) begin
      mismatched++;
      $display("FAIL R8 R2 R3 payload: actual %h expected %h at %0t", payload, ePay, $time);
    end
    if (strobe === 1'b1) strobeSeen++;
  endtask

  task automatic step(input bit b, input bit rst);
    @(negedge clk);
    compareOutputs();
    serialIn = b;
    rstN = !rst;
    if (rst) modelReset();
    else modelAdvance(b);
  endtask

  // kind: 0 good, 1 corrupted pattern, 2 good with pattern planted in data
  task automatic buildFrame(input int kind);
    for (int i = 0; i < frameN; i++) begin
      bit b;
      if (i < 6) b = (kind == 1) ? 1'b0 : FAW6[i];
      else if (kind == 2 && i >= 7 && i <= 10) b = (i == 8) ? 1'b0 : 1'b1;
      else if (i >= frameN - 2) b = 1'b0;
      else begin
        b = 1'($urandom_range(0, 1));
        if (l3 == 1 && l2 == 0 && l1 == 1) b = 1'b0;
      end
      fb[i] = b;
      l3 = l2; l2 = l1; l1 = b;
    end
  endtask

  task automatic sendBits(input int from, input int upto);
    for (int i = from; i < upto; i++) step(fb[i], 1'b0);
  endtask

  task automatic sendFrame(input int kind);
    buildFrame(kind);
    sendBits(0, frameN);
  endtask

  task automatic runConfig(input bit shortSel, input logic [1:0] sel);
    step(1'b0, 1'b1);
    shortFrame = shortSel;
    fawSel = sel;
    frameN = shortSel ? 16 : 32;
    fawL = (sel == 2'd0) ? 4 : (sel == 2'd1) ? 5 : 6;
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    // R1: reset state
    checkBit("R1 locked after reset", locked, 1'b0);
    checkBit("R1 strobe after reset", strobe, 1'b0);
    checkInt("R1 payload after reset", int'(payload), 0);
    l1 = 0; l2 = 0; l3 = 0;
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0);
    strobeSeen = 0;
    // R5: two hits then a miss must not lock
    sendFrame(0); sendFrame(0); sendFrame(1);
    buildFrame(0); sendBits(0, 3);
    checkBit("R5 no lock after broken confirm", locked, 1'b0);
    checkInt("R7 no strobe while unlocked", strobeSeen, 0);
    sendBits(3, frameN);
    // R4: acquire lock
    sendFrame(0); sendFrame(0);
    buildFrame(0); sendBits(0, 3);
    checkBit("R4 lock after three periodic hits", locked, 1'b1);
    strobeSeen = 0;
    sendBits(3, frameN);
    for (int f = 0; f < 4; f++) sendFrame(0);
    buildFrame(0); sendBits(0, 3);
    checkInt("R7 one strobe per locked frame", strobeSeen, 5);
    strobeSeen = 0;
    sendBits(3, frameN);
    // R9: planted off-phase pattern
    sendFrame(2);
    buildFrame(0); sendBits(0, 3);
    checkBit("R9 lock kept with off-phase pattern", locked, 1'b1);
    checkInt("R9 strobe count unchanged by off-phase pattern", strobeSeen, 2);
    sendBits(3, frameN);
    // R6: single miss tolerated
    sendFrame(1);
    buildFrame(0); sendBits(0, 3);
    checkBit("R6 lock kept after one miss", locked, 1'b1);
    sendBits(3, frameN);
    sendFrame(0);
    // R6: two misses drop lock
    sendFrame(1); sendFrame(1);
    buildFrame(0); sendBits(0, 3);
    checkBit("R6 lock dropped after two misses", locked, 1'b0);
    sendBits(3, frameN);
    sendFrame(0); sendFrame(0);
    buildFrame(0); sendBits(0, 3);
    checkBit("R4 relock after loss", locked, 1'b1);
    sendBits(3, frameN);
    // R1: reset while locked
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    checkBit("R1 reset clears lock", locked, 1'b0);
    checkBit("R1 reset clears strobe", strobe, 1'b0);
  endtask

  initial begin
    modelReset();
    l1 = 0; l2 = 0; l3 = 0;
    runConfig(1'b0, 2'd2);
    runConfig(1'b0, 2'd0);
    runConfig(1'b1, 2'd1);
    runConfig(1'b1, 2'd3);
    runConfig(1'b0, 2'd1);
    runConfig(1'b1, 2'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule